// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block decides when each of up to three supply rails is switched on and when the system may come out of reset. It watches a digital enable flag, one above-undervoltage flag per rail and one power-good comparator flag per rail. A mask can exclude individual rails. A mode input selects staggered start-up or joint start-up. In joint start-up an outside ramp generator slews the rails together. The block drives one enable line per rail, a power-good/reset line, and a fast-discharge line for abnormal shutdown.

Start-up begins once enable is high and every rail that is not excluded is above its undervoltage level. In staggered mode a wait interval runs before each active rail, and the rails are enabled strictly from index 0 upward. Each next interval begins only after the previous rail reports good. When every active rail is good, a hold-off interval runs and then the power-good line rises. Both intervals count clock ticks and come from loadable values with reset defaults. If enable drops or a fault is flagged before power-good, the block cuts every rail at once, asserts fast discharge and stays there until it is cleared. Dropping enable after power-good switches every rail off together.

Top module: `rail_seq_top`

## Requirements
- R1: After reset all rail enables, `pgood_o` and `fast_off_o` are low.
- R2: Start-up begins only in a cycle where `en_i` is high and `uv_ok_i[i]` is high for every rail i with `excl_i[i]` low. Otherwise all outputs stay low.
- R3: A rail's enable rises exactly D cycles after the clock edge that starts its wait interval. That edge is the start edge for the first active rail, or the edge that samples the previous rail good. D is the last value written with `dly_wr_i`. A written 0 counts as 1, and the default after reset is DEF_DLY.
- R4: With `trk_mode_i` = 0 sampled at start, active rails are enabled one per interval in order 0, 1, 2. The next wait interval does not begin until `pg_i` of the current rail is high.
- R5: A rail with its `excl_i` bit set at start is skipped with no wait interval, is never enabled, and counts as good. Its `uv_ok_i` and `pg_i` are ignored. With all rails excluded the hold-off interval starts at the start edge.
- R6: With `trk_mode_i` = 1 sampled at start, one wait interval runs and then all active rails are enabled in the same cycle. The block then waits until all of them report good. A later change of `trk_mode_i` has no effect on a running cycle.
- R7: `pgood_o` rises exactly T cycles after the edge that samples the last active rail good (or after the start edge when all are excluded). T is the last value written with `tmo_wr_i`, 0 counts as 1, and the default is DEF_TMO.
- R8: While `pgood_o` is low and start-up is running, `en_i` low or `fault_i` high causes an abort. At the next edge all rail enables go low and `fast_off_o` goes high.
- R9: `fast_off_o` stays high until an edge samples `en_i` low and `fault_i` low. At that edge it falls and the block returns to idle.
- R10: `en_i` low while `pgood_o` is high makes all rail enables and `pgood_o` fall together at the next edge, with `fast_off_o` staying low.
- R11: `fault_i` has no effect while `pgood_o` is high.
- R12: A rising `en_i` while all undervoltage flags are already high also runs the full wait interval before the first rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable above rising level |
| uv_ok_i | input | NRAIL | Per-rail above-undervoltage flags |
| pg_i | input | NRAIL | Per-rail power-good comparator flags |
| excl_i | input | NRAIL | Per-rail exclude mask, sampled at start |
| trk_mode_i | input | 1 | 0 staggered, 1 joint start-up; sampled at start |
| fault_i | input | 1 | Fault flag during start-up |
| dly_wr_i | input | 1 | Write strobe for the wait interval |
| dly_val_i | input | CNT_W | Wait interval in cycles |
| tmo_wr_i | input | 1 | Write strobe for the hold-off interval |
| tmo_val_i | input | CNT_W | Hold-off interval in cycles |
| rail_en_o | output | NRAIL | Per-rail switch enable |
| pgood_o | output | 1 | Power-good / reset release |
| fast_off_o | output | 1 | Fast-discharge request after an abort |

## Verification
The bench checks the exact cycle of every output change against counts computed from the loaded and default intervals. It covers a written interval of 0, and a design that counted from 0 or took one cycle too many would move every event off by one. It holds a rail's good flag back for many cycles, where a design that timed only the intervals would enable the next rail early. It leaves an excluded rail under voltage and never good; a design that did not drop excluded rails from its checks would never start or never finish. Aborts are forced in the wait-for-good and hold-off phases, and the trip is held with enable high. A design that released fast discharge on fault removal alone, or that treated an abort like an orderly shutdown, would show a wrong output change.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_WAITPG,
    ST_HOLD,
    ST_ON,
    ST_TRIP
  } seq_state_e;
endpackage

// File: rtl/rail_seq_cfg.sv
module rail_seq_cfg #(
  parameter int CNT_W   = 16,
  parameter int DEF_DLY = 200,
  parameter int DEF_TMO = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dly_wr_i,
  input  logic [CNT_W-1:0] dly_val_i,
  input  logic             tmo_wr_i,
  input  logic [CNT_W-1:0] tmo_val_i,
  output logic [CNT_W-1:0] dly_o,
  output logic [CNT_W-1:0] tmo_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] dly_q, tmo_q;

  // A zero interval is stored as one so the timer always spends a cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= CNT_W'(DEF_DLY);
      tmo_q <= CNT_W'(DEF_TMO);
    end else begin
      if (dly_wr_i) dly_q <= (dly_val_i == '0) ? ONE : dly_val_i;
      if (tmo_wr_i) tmo_q <= (tmo_val_i == '0) ? ONE : tmo_val_i;
    end
  end

  assign dly_o = dly_q;
  assign tmo_o = tmo_q;

  assert_cfg_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (dly_q != '0) && (tmo_q != '0));
endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // Loaded with N on the entry edge; done is seen in the Nth cycle after it.
  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (ld_i)           cnt_q <= ld_val_i;
    else if (cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q <= CNT_W'(1));

  assert_timer_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !done_o) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int NRAIL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [NRAIL-1:0] uv_ok_i,
  input  logic [NRAIL-1:0] pg_i,
  input  logic [NRAIL-1:0] excl_i,
  input  logic             trk_i,
  input  logic             fault_i,
  input  logic             tmr_done_i,
  output logic             ld_dly_o,
  output logic             ld_tmo_o,
  output logic [NRAIL-1:0] rail_en_o,
  output logic             pgood_o,
  output logic             trip_o
);
  localparam int IDX_W = (NRAIL > 1) ? $clog2(NRAIL) : 1;

  seq_state_e       state_q, nxt_state;
  logic [IDX_W-1:0] cur_q, nxt_cur;
  logic [NRAIL-1:0] act_q, nxt_act;
  logic [NRAIL-1:0] rail_en_q, nxt_en;
  logic             mode_q, nxt_mode;
  logic             pgood_q, nxt_pg;
  logic             trip_q, nxt_trip;
  logic [IDX_W:0]   hit;
  logic [NRAIL-1:0] rail_good, cur_bit;
  logic             start_ok, abort, cur_good;

  // Lowest active rail at or above 'from'; MSB flags a hit.
  function automatic logic [IDX_W:0] seek(input logic [NRAIL-1:0] m, input int from);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NRAIL - 1; i >= 0; i--)
      if (m[i] && (i >= from)) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    assign rail_good[i] = !act_q[i] || pg_i[i];
    assign cur_bit[i]   = (cur_q == IDX_W'(i));
  end

  assign start_ok = en_i && (&(uv_ok_i | excl_i));
  assign abort    = !en_i || fault_i;
  assign cur_good = mode_q ? (&rail_good) : (|(cur_bit & rail_good));

  always_comb begin
    nxt_state = state_q;
    nxt_cur   = cur_q;
    nxt_act   = act_q;
    nxt_en    = rail_en_q;
    nxt_mode  = mode_q;
    nxt_pg    = pgood_q;
    nxt_trip  = trip_q;
    ld_dly_o  = 1'b0;
    ld_tmo_o  = 1'b0;
    hit       = '0;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          nxt_mode = trk_i;
          nxt_act  = ~excl_i;
          hit      = seek(~excl_i, 0);
          if (hit[IDX_W]) begin
            nxt_cur   = hit[IDX_W-1:0];
            nxt_state = ST_DELAY;
            ld_dly_o  = 1'b1;
          end else begin
            nxt_state = ST_HOLD;
            ld_tmo_o  = 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (abort) begin
          nxt_state = ST_TRIP;
          nxt_en    = '0;
          nxt_trip  = 1'b1;
        end else if (tmr_done_i) begin
          nxt_en    = mode_q ? act_q : (rail_en_q | cur_bit);
          nxt_state = ST_WAITPG;
        end
      end
      ST_WAITPG: begin
        if (abort) begin
          nxt_state = ST_TRIP;
          nxt_en    = '0;
          nxt_trip  = 1'b1;
        end else if (cur_good) begin
          hit = mode_q ? '0 : seek(act_q, int'(cur_q) + 1);
          if (hit[IDX_W]) begin
            nxt_cur   = hit[IDX_W-1:0];
            nxt_state = ST_DELAY;
            ld_dly_o  = 1'b1;
          end else begin
            nxt_state = ST_HOLD;
            ld_tmo_o  = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (abort) begin
          nxt_state = ST_TRIP;
          nxt_en    = '0;
          nxt_trip  = 1'b1;
        end else if (tmr_done_i) begin
          nxt_state = ST_ON;
          nxt_pg    = 1'b1;
        end
      end
      ST_ON: begin
        if (!en_i) begin
          nxt_state = ST_IDLE;
          nxt_en    = '0;
          nxt_pg    = 1'b0;
        end
      end
      ST_TRIP: begin
        if (!en_i && !fault_i) begin
          nxt_state = ST_IDLE;
          nxt_trip  = 1'b0;
        end
      end
      default: begin
        nxt_state = ST_IDLE;
        nxt_en    = '0;
        nxt_pg    = 1'b0;
        nxt_trip  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      act_q     <= '0;
      rail_en_q <= '0;
      mode_q    <= 1'b0;
      pgood_q   <= 1'b0;
      trip_q    <= 1'b0;
    end else begin
      state_q   <= nxt_state;
      cur_q     <= nxt_cur;
      act_q     <= nxt_act;
      rail_en_q <= nxt_en;
      mode_q    <= nxt_mode;
      pgood_q   <= nxt_pg;
      trip_q    <= nxt_trip;
    end
  end

  assign rail_en_o = rail_en_q;
  assign pgood_o   = pgood_q;
  assign trip_o    = trip_q;

  // Rail enables only ever rise as the wait interval ends.
  for (genvar i = 0; i < NRAIL; i++) begin : g_chk_rise
    assert_rise_after_wait_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(rail_en_q[i]) |-> ($past(state_q) == ST_DELAY));
  end

  // Staggered mode: a rail is on only if every lower active rail is on.
  for (genvar i = 1; i < NRAIL; i++) begin : g_chk_order
    assert_rail_order_R4: assert property (@(posedge clk) disable iff (rst)
      (rail_en_q[i] && !mode_q) |-> (&(rail_en_q[i-1:0] | ~act_q[i-1:0])));
  end

  assert_one_at_a_time_R4: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> $onehot0(rail_en_q & ~$past(rail_en_q)));

  assert_excluded_off_R5: assert property (@(posedge clk) disable iff (rst)
    (rail_en_q & ~act_q) == '0);

  assert_pgood_all_on_R7: assert property (@(posedge clk) disable iff (rst)
    pgood_q |-> (rail_en_q == act_q) && !trip_q);

  assert_trip_all_off_R8: assert property (@(posedge clk) disable iff (rst)
    trip_q |-> (rail_en_q == '0) && !pgood_q);

  assert_orderly_off_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(pgood_q) |-> (rail_en_q == '0) && !trip_q);
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top #(
  parameter int NRAIL   = 3,
  parameter int CNT_W   = 16,
  parameter int DEF_DLY = 200,
  parameter int DEF_TMO = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [NRAIL-1:0] uv_ok_i,
  input  logic [NRAIL-1:0] pg_i,
  input  logic [NRAIL-1:0] excl_i,
  input  logic             trk_mode_i,
  input  logic             fault_i,
  input  logic             dly_wr_i,
  input  logic [CNT_W-1:0] dly_val_i,
  input  logic             tmo_wr_i,
  input  logic [CNT_W-1:0] tmo_val_i,
  output logic [NRAIL-1:0] rail_en_o,
  output logic             pgood_o,
  output logic             fast_off_o
);
  logic [CNT_W-1:0] dly_w, tmo_w, tmr_val;
  logic             ld_dly, ld_tmo, tmr_done;

  rail_seq_cfg #(.CNT_W(CNT_W), .DEF_DLY(DEF_DLY), .DEF_TMO(DEF_TMO)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .dly_wr_i  (dly_wr_i),
    .dly_val_i (dly_val_i),
    .tmo_wr_i  (tmo_wr_i),
    .tmo_val_i (tmo_val_i),
    .dly_o     (dly_w),
    .tmo_o     (tmo_w)
  );

  assign tmr_val = ld_dly ? dly_w : tmo_w;

  rail_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (ld_dly | ld_tmo),
    .ld_val_i (tmr_val),
    .done_o   (tmr_done)
  );

  rail_seq_fsm #(.NRAIL(NRAIL)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .uv_ok_i    (uv_ok_i),
    .pg_i       (pg_i),
    .excl_i     (excl_i),
    .trk_i      (trk_mode_i),
    .fault_i    (fault_i),
    .tmr_done_i (tmr_done),
    .ld_dly_o   (ld_dly),
    .ld_tmo_o   (ld_tmo),
    .rail_en_o  (rail_en_o),
    .pgood_o    (pgood_o),
    .trip_o     (fast_off_o)
  );

  assert_single_load_R3: assert property (@(posedge clk) disable iff (rst)
    !(ld_dly && ld_tmo));
endmodule

// File: tb/rail_seq_top_tb.sv
module rail_seq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, trk = 1'b0, fault = 1'b0;
  logic [2:0]  uv = '0, pg = '0, excl = '0;
  logic        dly_wr = 1'b0, tmo_wr = 1'b0;
  logic [15:0] dly_val = '0, tmo_val = '0;
  logic [2:0]  rail_en;
  logic        pgood, fast_off;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct packed {
    int         stamp;
    logic [2:0] en;
    logic       pg;
    logic       off;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rail_seq_top u_dut (
    .clk(clk), .rst(rst), .en_i(en), .uv_ok_i(uv), .pg_i(pg), .excl_i(excl),
    .trk_mode_i(trk), .fault_i(fault), .dly_wr_i(dly_wr), .dly_val_i(dly_val),
    .tmo_wr_i(tmo_wr), .tmo_val_i(tmo_val), .rail_en_o(rail_en), .pgood_o(pgood),
    .fast_off_o(fast_off)
  );

  // Driver side: queue an expected output change at a given cycle stamp.
  task automatic expect_ev(input int s, input logic [2:0] e, input logic p,
                           input logic o, input string tag);
    exp_t x;
    x.stamp = s; x.en = e; x.pg = p; x.off = o;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic go(input int s);
    while (cyc < s) @(negedge clk);
  endtask

  task automatic check_now(input string tag, input logic [2:0] e, input logic p,
                           input logic o);
    n_chk++;
    if (rail_en !== e || pgood !== p || fast_off !== o) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual en=%b pg=%b off=%b expected en=%b pg=%b off=%b",
               tag, cyc, rail_en, pgood, fast_off, e, p, o);
    end
  endtask

  task automatic cfg_write(input logic [15:0] d, input logic [15:0] t);
    dly_val = d; tmo_val = t; dly_wr = 1'b1; tmo_wr = 1'b1;
    @(negedge clk);
    dly_wr = 1'b0; tmo_wr = 1'b0;
  endtask

  // Monitor: every output change must match the head of the queue.
  initial begin
    logic [4:0] prev_v, cur_v;
    exp_t  x;
    string t;
    prev_v = '0;
    forever begin
      @(negedge clk);
      cur_v = {rail_en, pgood, fast_off};
      if (!rst && cur_v !== prev_v) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected change (R2/R11) cyc=%0d actual en=%b pg=%b off=%b expected no change",
                   cyc, rail_en, pgood, fast_off);
        end else begin
          x = exp_q.pop_front();
          t = tag_q.pop_front();
          if (x.stamp != cyc || x.en !== rail_en || x.pg !== pgood || x.off !== fast_off) begin
            n_bad++;
            $display("FAIL %s actual cyc=%0d en=%b pg=%b off=%b expected cyc=%0d en=%b pg=%b off=%b",
                     t, cyc, rail_en, pgood, fast_off, x.stamp, x.en, x.pg, x.off);
          end
        end
      end
      prev_v = cur_v;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (R1..) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_now("R1", 3'b000, 1'b0, 1'b0);

    // R2: one active rail under voltage blocks the start.
    en = 1'b1; uv = 3'b101;
    go(cyc + 10);
    check_now("R2", 3'b000, 1'b0, 1'b0);

    // R3 default wait of 200, R4 strict order gated by pg, R7 default hold-off.
    s = cyc; uv = 3'b111;
    expect_ev(s + 201, 3'b001, 1'b0, 1'b0, "R3");
    go(s + 201);
    go(cyc + 20);
    check_now("R4", 3'b001, 1'b0, 1'b0);
    s = cyc; pg = 3'b001;
    expect_ev(s + 201, 3'b011, 1'b0, 1'b0, "R4");
    go(s + 201);
    s = cyc; pg = 3'b011;
    expect_ev(s + 201, 3'b111, 1'b0, 1'b0, "R4");
    go(s + 201);
    s = cyc; pg = 3'b111;
    expect_ev(s + 201, 3'b111, 1'b1, 1'b0, "R7");
    go(s + 201);

    // R11: fault while good is ignored.
    fault = 1'b1;
    go(cyc + 5);
    check_now("R11", 3'b111, 1'b1, 1'b0);
    fault = 1'b0;

    // R10: orderly shutdown turns everything off together.
    s = cyc; en = 1'b0;
    expect_ev(s + 1, 3'b000, 1'b0, 1'b0, "R10");
    go(s + 1);

    // Loaded intervals: wait 5, hold-off 7.
    cfg_write(16'd5, 16'd7);

    // R5 and R12: rail 1 excluded, under voltage and never good; start by enable rise.
    pg = 3'b000; excl = 3'b010; uv = 3'b101;
    go(cyc + 2);
    s = cyc; en = 1'b1;
    expect_ev(s + 6, 3'b001, 1'b0, 1'b0, "R12");
    go(s + 6);
    s = cyc; pg = 3'b001;
    expect_ev(s + 6, 3'b101, 1'b0, 1'b0, "R5");
    go(s + 6);
    s = cyc; pg = 3'b101;
    expect_ev(s + 8, 3'b101, 1'b1, 1'b0, "R7");
    go(s + 8);
    s = cyc; en = 1'b0;
    expect_ev(s + 1, 3'b000, 1'b0, 1'b0, "R10");
    go(s + 1);

    // R6: joint start-up, waits for every active rail.
    excl = 3'b000; uv = 3'b111; pg = 3'b000; trk = 1'b1;
    go(cyc + 2);
    s = cyc; en = 1'b1;
    expect_ev(s + 6, 3'b111, 1'b0, 1'b0, "R6");
    go(s + 6);
    pg = 3'b011;
    go(cyc + 10);
    check_now("R6", 3'b111, 1'b0, 1'b0);
    s = cyc; pg = 3'b111;
    expect_ev(s + 8, 3'b111, 1'b1, 1'b0, "R6");
    go(s + 8);
    trk = 1'b0;
    go(cyc + 3);
    check_now("R6", 3'b111, 1'b1, 1'b0);
    s = cyc; en = 1'b0;
    expect_ev(s + 1, 3'b000, 1'b0, 1'b0, "R10");
    go(s + 1);

    // R8 and R9: fault while waiting for rail 0; trip holds while enable stays high.
    pg = 3'b000;
    go(cyc + 2);
    s = cyc; en = 1'b1;
    expect_ev(s + 6, 3'b001, 1'b0, 1'b0, "R3");
    go(s + 6);
    s = cyc; fault = 1'b1;
    expect_ev(s + 1, 3'b000, 1'b0, 1'b1, "R8");
    go(s + 1);
    fault = 1'b0;
    go(cyc + 5);
    check_now("R9", 3'b000, 1'b0, 1'b1);
    s = cyc; en = 1'b0;
    expect_ev(s + 1, 3'b000, 1'b0, 1'b0, "R9");
    go(s + 1);

    // R4 with good flags already high, then R8 abort by enable low during hold-off.
    pg = 3'b111;
    go(cyc + 2);
    s = cyc; en = 1'b1;
    expect_ev(s + 6,  3'b001, 1'b0, 1'b0, "R4");
    expect_ev(s + 12, 3'b011, 1'b0, 1'b0, "R4");
    expect_ev(s + 18, 3'b111, 1'b0, 1'b0, "R4");
    go(s + 20);
    en = 1'b0;
    expect_ev(s + 21, 3'b000, 1'b0, 1'b1, "R8");
    expect_ev(s + 22, 3'b000, 1'b0, 1'b0, "R9");
    go(s + 24);

    // R5: all rails excluded, hold-off starts at once.
    excl = 3'b111; uv = 3'b000; pg = 3'b000;
    go(cyc + 2);
    s = cyc; en = 1'b1;
    expect_ev(s + 8, 3'b000, 1'b1, 1'b0, "R5");
    go(s + 8);
    s = cyc; en = 1'b0;
    expect_ev(s + 1, 3'b000, 1'b0, 1'b0, "R10");
    go(s + 1);

    // R3: a written wait of 0 behaves as 1.
    cfg_write(16'd0, 16'd7);
    excl = 3'b000; uv = 3'b111; pg = 3'b111;
    go(cyc + 2);
    s = cyc; en = 1'b1;
    expect_ev(s + 2,  3'b001, 1'b0, 1'b0, "R3");
    expect_ev(s + 4,  3'b011, 1'b0, 1'b0, "R3");
    expect_ev(s + 6,  3'b111, 1'b0, 1'b0, "R3");
    expect_ev(s + 14, 3'b111, 1'b1, 1'b0, "R7");
    go(s + 14);
    s = cyc; en = 1'b0;
    expect_ev(s + 1, 3'b000, 1'b0, 1'b0, "R10");
    go(s + 5);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL missing events (R3/R7) actual pending=%0d expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule